// File: doc/BRIEF.md
# CSR Read-Modify-Write Execution Unit

This unit carries out the six control-and-status-register access operations of a 32-bit integer core. Each cycle it can accept one decoded SYSTEM-class instruction word, the value of the source register, and a valid strobe. It drives an external CSR storage port with an address, a read enable, a write enable and the write data. The old register value comes back combinationally on that port. The unit then forms the new value by swapping it, setting bits in it or clearing bits in it.

The old value is registered once and returned for writeback to the destination register, together with a write enable and the destination index. The central task is to gate the read and write enables exactly. A read is skipped for a swap whose destination is x0. A write is skipped for a set or clear whose source field is zero. A source register other than x0 that holds zero still produces a write. An actual write to a read-only register is blocked and raises an illegal-instruction flag.

Top module: `csr_rmw_unit`

## Requirements
- R1: The instruction fields are: destination index at bits 11:7, operation code at bits 14:12, source index or immediate at bits 19:15, CSR address at bits 31:20, and major opcode at bits 6:0, which must be 7'b1110011. Operation codes 000 and 100, or any other major opcode, produce no read, no write, no writeback and no illegal flag.
- R2: Swap operations (code 001 with the register operand, code 101 with the immediate operand) write the operand to the CSR. They assert the read enable only when the destination index is nonzero.
- R3: Set operations (010 and 110) write the old value OR the operand. Clear operations (011 and 111) write the old value AND NOT the operand.
- R4: Set and clear operations always assert the read enable. They assert no write when the source field at bits 19:15 is zero.
- R5: A set or clear whose source index is nonzero writes even when the register value is zero. In that case the write data equals the old value.
- R6: Codes 101, 110 and 111 use the 5-bit source field, zero-extended to 32 bits, as the operand. The source register value is ignored.
- R7: A CSR address with bits 11:10 equal to 2'b11 is read-only. An intended write to such an address asserts no write enable, sets illegal_o one cycle later and suppresses the writeback. A read-only access with no intended write raises no flag.
- R8: One cycle after an accepted operation, rd_we_o is 1 exactly when the destination index is nonzero and no illegal flag is raised. rd_addr_o then carries the destination index and rd_data_o the old CSR value.
- R9: With valid_i low, neither CSR enable is asserted, and rd_we_o and illegal_o are 0 in the following cycle.
- R10: While reset is asserted, rd_we_o, illegal_o, rd_addr_o and rd_data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction valid strobe |
| instr_i | input | 32 | Instruction word |
| rs1_val_i | input | 32 | Source register value |
| csr_addr_o | output | 12 | CSR address |
| csr_re_o | output | 1 | CSR read enable |
| csr_we_o | output | 1 | CSR write enable |
| csr_wdata_o | output | 32 | CSR write data |
| csr_rdata_i | input | 32 | Old CSR value from storage |
| rd_we_o | output | 1 | Destination writeback enable |
| rd_addr_o | output | 5 | Destination register index |
| rd_data_o | output | 32 | Old CSR value for writeback |
| illegal_o | output | 1 | Illegal write to a read-only CSR |

## Verification
A swap or a set/clear can read the old value and write the new one in the same cycle. On a read-only address, the write is refused while the read and the writeback may still be active. The bench provokes both situations with random operations on a mix of writable and read-only addresses, random zero and nonzero destination and source fields, and zero register values. It models the CSR storage itself and predicts the enables, the write data, the flag and the registered writeback from the requirements. It judges the port outputs in the issue cycle and the writeback outputs one cycle later.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned IDX_W  = 5;
  localparam logic [6:0]  OPC_SYSTEM = 7'b1110011;
  localparam logic [1:0]  RO_TAG     = 2'b11;

  typedef enum logic [1:0] {
    ALU_NONE = 2'b00,
    ALU_SWAP = 2'b01,
    ALU_SET  = 2'b10,
    ALU_CLR  = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic              hit;
    alu_op_e           op;
    logic              use_imm;
    logic [IDX_W-1:0]  src;
    logic [IDX_W-1:0]  rd;
    logic [ADDR_W-1:0] addr;
  } dec_t;
endpackage

// File: rtl/csr_rmw_decode.sv
module csr_rmw_decode
  import csr_rmw_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] instr_i,
  output dec_t        dec_o
);
  logic [2:0] f3;
  assign f3 = instr_i[14:12];

  always_comb begin
    dec_o.addr    = instr_i[31:20];
    dec_o.src     = instr_i[19:15];
    dec_o.rd      = instr_i[11:7];
    dec_o.use_imm = f3[2];
    unique case (f3[1:0])
      2'b01:   dec_o.op = ALU_SWAP;
      2'b10:   dec_o.op = ALU_SET;
      2'b11:   dec_o.op = ALU_CLR;
      default: dec_o.op = ALU_NONE;
    endcase
    dec_o.hit = valid_i && (instr_i[6:0] == OPC_SYSTEM) && (f3[1:0] != 2'b00);
  end
endmodule

// File: rtl/csr_rmw_gate.sv
module csr_rmw_gate
  import csr_rmw_pkg::*;
(
  input  dec_t dec_i,
  output logic re_o,
  output logic we_o,
  output logic illegal_o
);
  logic is_swap, rd_zero, src_zero, ro, wr_intent;

  always_comb begin
    is_swap   = (dec_i.op == ALU_SWAP);
    rd_zero   = (dec_i.rd == '0);
    src_zero  = (dec_i.src == '0);
    ro        = (dec_i.addr[ADDR_W-1 -: 2] == RO_TAG);
    // swap with rd=x0 skips the read; set/clear always read
    re_o      = dec_i.hit && !(is_swap && rd_zero);
    // set/clear with zero source field skips the write, whatever the register holds
    wr_intent = dec_i.hit && (is_swap || !src_zero);
    illegal_o = wr_intent && ro;
    we_o      = wr_intent && !ro;
  end
endmodule

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
  import csr_rmw_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] operand_i,
  input  logic [XLEN-1:0] old_i,
  output logic [XLEN-1:0] new_o
);
  always_comb begin
    unique case (op_i)
      ALU_SWAP: new_o = operand_i;
      ALU_SET:  new_o = old_i | operand_i;
      ALU_CLR:  new_o = old_i & ~operand_i;
      default:  new_o = old_i;
    endcase
  end
endmodule

// File: rtl/csr_rmw_wb.sv
module csr_rmw_wb
  import csr_rmw_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             illegal_i,
  input  logic [IDX_W-1:0] rd_i,
  input  logic [XLEN-1:0]  rdata_i,
  output logic             rd_we_o,
  output logic [IDX_W-1:0] rd_addr_o,
  output logic [XLEN-1:0]  rd_data_o,
  output logic             illegal_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_we_o   <= 1'b0;
      rd_addr_o <= '0;
      rd_data_o <= '0;
      illegal_o <= 1'b0;
    end else begin
      rd_we_o   <= hit_i && (rd_i != '0) && !illegal_i;
      illegal_o <= illegal_i;
      if (hit_i) begin
        rd_addr_o <= rd_i;
        rd_data_o <= rdata_i;
      end
    end
  end

  AST_WB_DATA_OLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_data_o == $past(rdata_i)));  // R8
  AST_WB_NOT_X0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (rd_addr_o != '0));  // R8
  AST_ILL_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !rd_we_o);  // R7
endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  output logic [ADDR_W-1:0] csr_addr_o,
  output logic              csr_re_o,
  output logic              csr_we_o,
  output logic [XLEN-1:0]   csr_wdata_o,
  input  logic [XLEN-1:0]   csr_rdata_i,
  output logic              rd_we_o,
  output logic [IDX_W-1:0]  rd_addr_o,
  output logic [XLEN-1:0]   rd_data_o,
  output logic              illegal_o
);
  dec_t            dec;
  logic            ill_now;
  logic [XLEN-1:0] operand;

  csr_rmw_decode u_dec (
    .valid_i (valid_i),
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  csr_rmw_gate u_gate (
    .dec_i     (dec),
    .re_o      (csr_re_o),
    .we_o      (csr_we_o),
    .illegal_o (ill_now)
  );

  // immediate variants zero-extend the 5-bit source field
  assign operand    = dec.use_imm ? {{(XLEN-IDX_W){1'b0}}, dec.src} : rs1_val_i;
  assign csr_addr_o = dec.addr;

  csr_rmw_alu #(.XLEN(XLEN)) u_alu (
    .op_i      (dec.op),
    .operand_i (operand),
    .old_i     (csr_rdata_i),
    .new_o     (csr_wdata_o)
  );

  csr_rmw_wb #(.XLEN(XLEN)) u_wb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hit_i     (dec.hit),
    .illegal_i (ill_now),
    .rd_i      (dec.rd),
    .rdata_i   (csr_rdata_i),
    .rd_we_o   (rd_we_o),
    .rd_addr_o (rd_addr_o),
    .rd_data_o (rd_data_o),
    .illegal_o (illegal_o)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!csr_re_o && !csr_we_o));  // R9
  AST_RO_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_we_o |-> (csr_addr_o[ADDR_W-1 -: 2] != RO_TAG));  // R7
  AST_ILL_FROM_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ($past(csr_addr_o[ADDR_W-1 -: 2]) == RO_TAG));  // R7
  AST_WB_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> $past(csr_re_o));  // R8
  AST_SET_KEEPS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_o && instr_i[13:12] == 2'b10) |-> ((csr_wdata_o & csr_rdata_i) == csr_rdata_i));  // R3
  AST_CLR_NO_NEW_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_o && instr_i[13:12] == 2'b11) |-> ((csr_wdata_o & ~csr_rdata_i) == '0));  // R3
endmodule

// File: tb/tb_csr_rmw_unit.sv
`timescale 1ns/1ps
module tb_csr_rmw_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] rs1_val_i = '0;
  logic [11:0] csr_addr_o;
  logic        csr_re_o, csr_we_o;
  logic [31:0] csr_wdata_o, csr_rdata_i;
  logic        rd_we_o, illegal_o;
  logic [4:0]  rd_addr_o;
  logic [31:0] rd_data_o;

  logic [31:0] mem [8];
  int n_chk = 0, n_fail = 0;
  bit  done = 0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  csr_rmw_unit dut (.*);

  assign csr_rdata_i = mem[csr_addr_o[2:0]];
  always @(posedge clk_i) if (csr_we_o) mem[csr_addr_o[2:0]] <= csr_wdata_o;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic [11:0] a, logic [4:0] s, logic [2:0] f, logic [4:0] d);
    return {a, s, f, d, 7'b1110011};
  endfunction

  // one operation: checks port side in issue cycle, writeback next cycle
  task automatic run_op(logic v, logic [31:0] ins, logic [31:0] rv);
    logic hit, swap, ro, wint, e_re, e_we, e_ill, e_rdwe;
    logic [31:0] opnd, old, e_wd;
    logic [4:0] s, d;
    logic [2:0] f;
    s = ins[19:15]; d = ins[11:7]; f = ins[14:12];
    hit  = v && ins[6:0] == 7'b1110011 && f[1:0] != 2'b00;
    swap = f[1:0] == 2'b01;
    ro   = ins[31:30] == 2'b11;
    e_re = hit && !(swap && d == 0);
    wint = hit && (swap || s != 0);
    e_ill = wint && ro;
    e_we  = wint && !ro;
    e_rdwe = hit && d != 0 && !e_ill;
    opnd = f[2] ? {27'd0, s} : rv;
    old  = mem[ins[22:20]];
    e_wd = swap ? opnd : (f[1:0] == 2'b10 ? (old | opnd) : (old & ~opnd));
    valid_i = v; instr_i = ins; rs1_val_i = rv;
    #1;
    check("R2 csr_re_o", {31'd0, csr_re_o}, {31'd0, e_re});
    check("R4 csr_we_o", {31'd0, csr_we_o}, {31'd0, e_we});
    if (e_we) check("R3 csr_wdata_o", csr_wdata_o, e_wd);
    @(posedge clk_i);
    @(negedge clk_i);
    check("R7 illegal_o", {31'd0, illegal_o}, {31'd0, e_ill});
    check("R8 rd_we_o", {31'd0, rd_we_o}, {31'd0, e_rdwe});
    if (e_rdwe) begin
      check("R8 rd_data_o", rd_data_o, old);
      check("R8 rd_addr_o", {27'd0, rd_addr_o}, {27'd0, d});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) mem[i] = 32'hA5A5_0000 + i;
    #2;
    // R10 reset state
    check("R10 rd_we_o", {31'd0, rd_we_o}, 32'd0);
    check("R10 illegal_o", {31'd0, illegal_o}, 32'd0);
    check("R10 rd_data_o", rd_data_o, 32'd0);
    check("R10 rd_addr_o", {27'd0, rd_addr_o}, 32'd0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 swap, read and write in the same cycle
    run_op(1, mk(12'h340, 5'd3, 3'b001, 5'd7), 32'hDEAD_BEEF);
    check("R2 swap stored", mem[0], 32'hDEAD_BEEF);
    // R2 swap to x0 skips read
    run_op(1, mk(12'h341, 5'd3, 3'b001, 5'd0), 32'h1234_5678);
    check("R2 no read rd=x0", {31'd0, csr_re_o}, 32'd0);
    // R4 set with rs1=x0: read only
    mem[2] = 32'h0000_00F0;
    run_op(1, mk(12'h342, 5'd0, 3'b010, 5'd4), 32'hFFFF_FFFF);
    check("R4 value kept", mem[2], 32'h0000_00F0);
    // R5 clear with non-x0 zero register still writes
    valid_i = 1; instr_i = mk(12'h342, 5'd9, 3'b011, 5'd4); rs1_val_i = 0; #1;
    check("R5 we on zero reg", {31'd0, csr_we_o}, 32'd1);
    check("R5 wdata old", csr_wdata_o, 32'h0000_00F0);
    @(negedge clk_i);
    // R6 immediate zero-extended, register ignored
    mem[3] = 32'h8000_0000;
    valid_i = 1; instr_i = mk(12'h343, 5'h1F, 3'b110, 5'd1); rs1_val_i = 32'hFFFF_0000; #1;
    check("R6 imm set", csr_wdata_o, 32'h8000_001F);
    @(negedge clk_i);
    valid_i = 1; instr_i = mk(12'h343, 5'h15, 3'b101, 5'd1); rs1_val_i = 32'hFFFF_FFFF; #1;
    check("R6 imm swap", csr_wdata_o, 32'h0000_0015);
    @(negedge clk_i);
    // R4 clear-immediate with uimm=0
    run_op(1, mk(12'h343, 5'd0, 3'b111, 5'd2), 32'hFFFF_FFFF);
    // R7 write to read-only address, read and flag in one op
    run_op(1, mk(12'hC00, 5'd1, 3'b001, 5'd5), 32'h1111_1111);
    check("R7 ro illegal", {31'd0, illegal_o}, 32'd1);
    check("R7 ro no wb", {31'd0, rd_we_o}, 32'd0);
    // R7 read-only read without write is legal
    run_op(1, mk(12'hC01, 5'd0, 3'b010, 5'd6), 32'h0);
    check("R7 ro read legal", {31'd0, illegal_o}, 32'd0);
    check("R7 ro read wb", {31'd0, rd_we_o}, 32'd1);
    // R1 non-CSR codes and other opcode
    run_op(1, mk(12'h340, 5'd3, 3'b100, 5'd7), 32'h5);
    check("R1 code 100 quiet", {31'd0, rd_we_o}, 32'd0);
    run_op(1, mk(12'h340, 5'd3, 3'b000, 5'd7), 32'h5);
    run_op(1, {12'h340, 5'd3, 3'b001, 5'd7, 7'b0110011}, 32'h5);
    check("R1 other opcode quiet", {31'd0, rd_we_o}, 32'd0);
    // R9 valid low
    run_op(0, mk(12'h340, 5'd3, 3'b001, 5'd7), 32'h5);
    check("R9 idle no wb", {31'd0, rd_we_o}, 32'd0);

    // random mix: R1..R9 via model
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [4:0] s, d;
      logic [2:0] f;
      logic [31:0] rv;
      logic v;
      a = {$urandom_range(0, 3) == 0 ? 2'b11 : 2'($urandom), 7'($urandom), 3'($urandom)};
      s = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      d = ($urandom_range(0, 3) == 0) ? 5'd0 : 5'($urandom);
      f = 3'($urandom);
      rv = ($urandom_range(0, 4) == 0) ? 32'd0 : $urandom;
      v = ($urandom_range(0, 7) != 0);
      run_op(v, mk(a, s, f, d), rv);
    end
    valid_i = 0;
    @(negedge clk_i);
    finish_run();
  end
endmodule